// File: doc/BRIEF.md
# Configurable Current-Mode PWM Generator

This block produces the gate-drive pulse for a buck converter under sampled current-mode control. A single free-running counter and one magnitude comparator serve all three current-mode variants. The counting direction, the comparator polarity and the way a duty count turns into a compare threshold all change together with the selected mode:

- In valley timing the switch turns on at the start of every switching period.
- In peak timing the switch turns off at the start of every switching period.
- In average timing the on-time is centred inside a period that the counter sweeps up and then down.

Every switching period opens with a one-cycle strobe. The surrounding controller uses it to sample the inductor current and to present the next duty count.

The controller drives a duty count, measured in clock cycles, and a mode code. It can write a new period length into a holding register at any time. None of these values disturbs the running period. The block takes all of them together in the final counter cycle of a period, and they govern the whole of the next period. A zero duty holds the output low. A duty equal to or above the period holds it high. In both cases there are no stray pulses across period boundaries.

Top module: `cm_dpwm`

## Requirements
- R1: Mode code 0 (valley): a period lasts P clock cycles, where P is the effective period length. The output is high for the first D cycles of the period and low for the rest, where D is the duty count clamped to P.
- R2: Mode code 1 (peak): a period lasts P cycles. The output is low for the first P−D cycles and high for the last D cycles.
- R3: Mode code 2 (average): the counter rises and then falls. It holds its top value for two cycles, so a period lasts 2·floor(P/2) cycles. With H = floor(P/2) and K = floor(D/2), the output is high exactly in cycles H−K to H+K−1 of the period, so the high time is centred.
- R4: `strobe_o` is high for exactly one cycle per period, in the first cycle of that period. That cycle is aligned with the first `pwm_o` cycle of the period.
- R5: Mode, duty and period-register values are captured in the last counter cycle of a period and apply from the next period on. Values presented earlier in a period have no effect on any period.
- R6: A pulse on `period_we_i` loads `period_i` into the period register at any cycle, including the final cycle of a period. The running period keeps its length, and the new length starts at the next period.
- R7: A duty count of 0 keeps `pwm_o` low for the whole period in every mode. A duty count of P or more keeps it high for the whole period in every mode, across back-to-back periods as well.
- R8: A period register value below 2 acts as 2, and mode code 3 behaves as valley mode.
- R9: While `rst_ni` is low, both outputs are low. After release, the first period runs in valley mode with the PER_RST length and zero duty. Its start is marked by a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the counter advances once per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Current-mode select: 0 valley, 1 peak, 2 average, 3 as valley |
| duty_i | input | CNT_W | Duty count in clock cycles |
| period_i | input | CNT_W | Period length in clock cycles for the period register |
| period_we_i | input | 1 | Write strobe for the period register |
| pwm_o | output | 1 | Gate-drive PWM output (registered) |
| strobe_o | output | 1 | One-cycle start-of-period strobe (registered) |

## Verification
The inputs are taken in the last counter cycle of a period. The outputs are registered, so the output period trails the counter by one cycle. Duty, mode and period writes therefore show up in the output period that follows the next strobe. The bench samples at falling edges. It presents the final duty and mode values no later than the second-to-last output cycle of the current period and issues any period write no later than that cycle. It treats earlier input values in the period as decoys. It then checks every cycle of the following period against a window computed from the requirement formulas, and it expects the strobe exactly one period length after the previous one. After reset release the synchronizer adds two cycles, so the bench waits for the first strobe and only checks that both outputs stay low until it arrives.

// File: rtl/cm_dpwm_pkg.sv
package cm_dpwm_pkg;

  typedef enum logic [1:0] {
    MODE_VALLEY = 2'd0,
    MODE_PEAK   = 2'd1,
    MODE_CENTER = 2'd2,
    MODE_RSVD   = 2'd3
  } pwm_mode_e;

endpackage

// File: rtl/cm_dpwm_bank.sv
// Period holding register plus the active set (mode, period, threshold,
// polarity) that is reloaded only on a period boundary.
module cm_dpwm_bank
  import cm_dpwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PER_RST = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] per_data_i,
  input  logic             per_we_i,
  input  logic             load_i,
  output pwm_mode_e        act_mode_o,
  output logic [CNT_W-1:0] act_per_o,
  output logic [CNT_W-1:0] act_cmp_o,
  output logic             act_inv_o
);

  localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);
  localparam logic [CNT_W-1:0] RST_RAW = CNT_W'(PER_RST);
  localparam logic [CNT_W-1:0] RST_PER = (RST_RAW < MIN_PER) ? MIN_PER : RST_RAW;

  logic [CNT_W-1:0] per_q, per_nx, per_eff, half_eff, duty_c;
  logic [CNT_W-1:0] cmp_nx;
  logic             inv_nx;
  pwm_mode_e        mode_n;

  pwm_mode_e        act_mode_q;
  logic [CNT_W-1:0] act_per_q, act_cmp_q;
  logic             act_inv_q;

  // Next-state: mapping of the pending duty onto a compare threshold
  always_comb begin
    per_nx   = per_we_i ? per_data_i : per_q;
    per_eff  = (per_nx < MIN_PER) ? MIN_PER : per_nx;
    half_eff = per_eff >> 1;
    mode_n   = pwm_mode_e'(mode_i);
    if (mode_n == MODE_RSVD) mode_n = MODE_VALLEY;
    duty_c   = (duty_i > per_eff) ? per_eff : duty_i;
    cmp_nx   = duty_c;
    inv_nx   = 1'b0;
    case (mode_n)
      MODE_PEAK: begin
        cmp_nx = per_eff - duty_c;
        inv_nx = 1'b1;
      end
      MODE_CENTER: begin
        cmp_nx = half_eff - (duty_c >> 1);
        inv_nx = 1'b1;
      end
      default: begin
        cmp_nx = duty_c;
        inv_nx = 1'b0;
      end
    endcase
  end

  // Period holding register, written at any time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= RST_RAW;
    end else if (per_we_i) begin
      per_q <= per_data_i;
    end
  end

  // Active set, reloaded only on the boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_mode_q <= MODE_VALLEY;
      act_per_q  <= RST_PER;
      act_cmp_q  <= '0;
      act_inv_q  <= 1'b0;
    end else if (load_i) begin
      act_mode_q <= mode_n;
      act_per_q  <= per_eff;
      act_cmp_q  <= cmp_nx;
      act_inv_q  <= inv_nx;
    end
  end

  assign act_mode_o = act_mode_q;
  assign act_per_o  = act_per_q;
  assign act_cmp_o  = act_cmp_q;
  assign act_inv_o  = act_inv_q;

  // R8
  act_per_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_per_q >= MIN_PER);

endmodule

// File: rtl/cm_dpwm_counter.sv
// Period counter: wrapping up-count for valley/peak, up-down sweep for
// average mode. Flags the last cycle and marks the first cycle.
module cm_dpwm_counter
  import cm_dpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pwm_mode_e        mode_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             end_o,
  output logic             first_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, half, top_up;
  logic             dn_q, dn_d, first_q, end_c;

  always_comb begin
    half   = per_i >> 1;
    top_up = per_i - ONE;
    cnt_d  = cnt_q;
    dn_d   = dn_q;
    end_c  = 1'b0;
    if (mode_i == MODE_CENTER) begin
      if (dn_q) begin
        if (cnt_q == '0) begin
          end_c = 1'b1;
          dn_d  = 1'b0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end else if (cnt_q == half - ONE) begin
        dn_d = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      dn_d = 1'b0;
      if (cnt_q == top_up) begin
        end_c = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      dn_q    <= 1'b0;
      first_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      dn_q    <= dn_d;
      first_q <= end_c;
    end
  end

  assign cnt_o   = cnt_q;
  assign end_o   = end_c;
  assign first_o = first_q;

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < per_i);

  // R3
  center_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CENTER) |-> (cnt_q < half));

  // R4
  first_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> (cnt_q == '0 && !dn_q));

endmodule

// File: rtl/cm_dpwm_compare.sv
// Magnitude comparator with mode-dependent polarity and registered outputs.
module cm_dpwm_compare #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             inv_i,
  input  logic             first_i,
  output logic             pwm_o,
  output logic             stb_o
);

  logic below, pwm_d, pwm_q, stb_q;

  always_comb begin
    below = (cnt_i < cmp_i);
    pwm_d = inv_i ? ~below : below;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
      stb_q <= first_i;
    end
  end

  assign pwm_o = pwm_q;
  assign stb_o = stb_q;

  // R7
  zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i == '0 && !inv_i) |=> !pwm_q);

  // R7
  full_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i == '0 && inv_i) |=> pwm_q);

  // R4
  strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);

endmodule

// File: rtl/cm_dpwm.sv
module cm_dpwm
  import cm_dpwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PER_RST = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             period_we_i,
  output logic             pwm_o,
  output logic             strobe_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  pwm_mode_e        act_mode;
  logic [CNT_W-1:0] act_per, act_cmp, cnt;
  logic             act_inv, per_end, per_first;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  cm_dpwm_bank #(.CNT_W(CNT_W), .PER_RST(PER_RST)) bank_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .mode_i     (mode_i),
    .duty_i     (duty_i),
    .per_data_i (period_i),
    .per_we_i   (period_we_i),
    .load_i     (per_end),
    .act_mode_o (act_mode),
    .act_per_o  (act_per),
    .act_cmp_o  (act_cmp),
    .act_inv_o  (act_inv)
  );

  cm_dpwm_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .mode_i  (act_mode),
    .per_i   (act_per),
    .cnt_o   (cnt),
    .end_o   (per_end),
    .first_o (per_first)
  );

  cm_dpwm_compare #(.CNT_W(CNT_W)) cmp_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .cnt_i   (cnt),
    .cmp_i   (act_cmp),
    .inv_i   (act_inv),
    .first_i (per_first),
    .pwm_o   (pwm_o),
    .stb_o   (strobe_o)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_n_int |=> (!pwm_o && !strobe_o) || rst_n_int);

endmodule

// File: tb/cm_dpwm_tb_top.sv
`timescale 1ns/1ps
module cm_dpwm_tb_top;
  localparam int CNT_W   = 8;
  localparam int PER_RST = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode;
  logic [CNT_W-1:0] duty, per_in;
  logic             per_we;
  logic             pwm, stb;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;
  int    cur_m, cur_p, cur_d;
  string cur_tag;

  always #2.5 clk = ~clk;

  cm_dpwm #(.CNT_W(CNT_W), .PER_RST(PER_RST)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .duty_i      (duty),
    .period_i    (per_in),
    .period_we_i (per_we),
    .pwm_o       (pwm),
    .strobe_o    (stb)
  );

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int eff_per(int p);
    return (p < 2) ? 2 : p;
  endfunction

  function automatic int plen(int m, int p);
    int pe = eff_per(p);
    return (m == 2) ? (pe / 2) * 2 : pe;
  endfunction

  // Expected output in cycle i of a period, from the requirement formulas
  function automatic int exp_pwm(int m, int p, int d, int i);
    int pe = eff_per(p);
    int dc = (d > pe) ? pe : d;
    int h, k;
    if (m == 1) return (i >= pe - dc) ? 1 : 0;
    if (m == 2) begin
      h = pe / 2;
      k = dc / 2;
      return (i >= h - k && i < h + k) ? 1 : 0;
    end
    return (i < dc) ? 1 : 0;
  endfunction

  function automatic string mode_tag(int m);
    if (m == 1) return "R2";
    if (m == 2) return "R3";
    if (m == 3) return "R8";
    return "R1";
  endfunction

  // Check the running period; set up the one after it (decoys first)
  task automatic run_period(int nm, int nd, int np, int wr_at, string ntag);
    int len = plen(cur_m, cur_p);
    int wa  = wr_at % (len - 1);
    for (int i = 0; i < len; i++) begin
      check(stb == (i == 0), "R4", int'(stb), (i == 0) ? 1 : 0);
      check(int'(pwm) == exp_pwm(cur_m, cur_p, cur_d, i), cur_tag,
            int'(pwm), exp_pwm(cur_m, cur_p, cur_d, i));
      if (i == 0) begin
        mode = 2'($urandom);
        duty = CNT_W'($urandom);
      end
      per_we = (np >= 0 && i == wa);
      if (per_we) per_in = CNT_W'(np);
      if (i == len - 2) begin
        mode = 2'(nm);
        duty = CNT_W'(nd);
      end
      @(negedge clk);
    end
    cur_m   = (nm == 3) ? 0 : nm;
    cur_d   = nd;
    if (np >= 0) cur_p = np;
    cur_tag = ntag;
  endtask

  initial begin
    int waitc;
    void'($urandom(32'd2024));
    rst_n  = 1'b0;
    mode   = 2'd0;
    duty   = '0;
    per_in = '0;
    per_we = 1'b0;
    repeat (3) @(negedge clk);
    check(pwm == 1'b0, "R9", int'(pwm), 0);
    check(stb == 1'b0, "R9", int'(stb), 0);
    rst_n = 1'b1;
    waitc = 0;
    while (!stb && waitc < 10) begin
      check(pwm == 1'b0, "R9", int'(pwm), 0);
      @(negedge clk);
      waitc++;
    end
    check(stb == 1'b1, "R9", int'(stb), 1);
    cur_m = 0; cur_p = PER_RST; cur_d = 0; cur_tag = "R9";

    // Directed corner cases
    run_period(0, 5,   -1, 0, "R1");
    run_period(0, 0,   -1, 0, "R7");
    run_period(0, 16,  -1, 0, "R7");
    run_period(0, 16,  -1, 0, "R7");
    run_period(1, 5,   -1, 0, "R2");
    run_period(1, 0,   -1, 0, "R7");
    run_period(1, 200, -1, 0, "R7");
    run_period(2, 7,   -1, 0, "R3");
    run_period(2, 7,   15, 3, "R3/R6");
    run_period(2, 15,  -1, 0, "R7");
    run_period(3, 4,   -1, 0, "R8");
    run_period(0, 1,    1, 2, "R8");
    run_period(1, 1,    0, 0, "R8");
    run_period(2, 2,   -1, 0, "R8");
    run_period(0, 3,   20, 99, "R6");
    run_period(1, 9,   -1, 0, "R2/R5");

    // Constrained random periods
    for (int r = 0; r < 40; r++) begin
      int nm = int'($urandom % 4);
      int np = ($urandom % 3 == 0) ? int'($urandom % 41) : -1;
      int pe = eff_per((np >= 0) ? np : cur_p);
      int nd = int'($urandom % (pe + 6));
      int wa = int'($urandom % 64);
      run_period(nm, nd, np, wa, $sformatf("%s/R5/R6", mode_tag(nm)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R4 watchdog: got 0 expected 1 completed run");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule